// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer for a processor subsystem. A prescaler that is never cleared divides the bus clock by a fixed power of two and produces a base tick. A post-divider counts base ticks up to a limit set by a 2-bit rate code. If software does not service the timer before the post-divider runs out, the block raises a one-clock reset request for the system reset controller.

Software services the timer with two byte writes to the service register. The first write is the arm key 0x55 and the second is the clear key 0xAA. Writes to other addresses may fall between the two keys. The prescaler keeps running through a service, so the real timeout can exceed the nominal period by up to one base period. It is never shorter than nominal.

After a timeout the block stays tripped until the system reset is applied. While the enable input is low, the post-divider and the armed state are held cleared.

Top module: `wdg_keyed`

## Requirements
- R1: After reset, resetReq is low, the armed state is clear and both counters are zero.
- R2: The base tick occurs once every 2^PRE_BITS clocks from a prescaler that only reset clears. A service write does not realign it, so the service-to-timeout delay depends on the phase of the service.
- R3: Rate code c (0 to 3) sets a limit of 4^c base periods. From a completed service to the resetReq pulse, the delay is more than limit*2^PRE_BITS clocks and at most (limit+1)*2^PRE_BITS clocks.
- R4: A service-register write (wrEn=1, wrSel=1) of 0x55 sets the armed state.
- R5: A service-register write of 0xAA while armed clears the post-divider and clears the armed state.
- R6: Writes with wrSel=0 have no effect on the armed state, so a sequence 0x55, other-address writes, 0xAA still services the timer.
- R7: A service-register write of 0xAA while not armed has no effect and the timeout proceeds.
- R8: A service-register write of any value other than 0x55 or 0xAA clears the armed state, so a following 0xAA does not service.
- R9: On expiry, resetReq is high for exactly one clock. No further pulse follows until rstN is asserted, whatever is written.
- R10: While enable is low, the post-divider and the armed state are held cleared. The full timeout starts again when enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| enable | input | 1 | Watchdog enable; low holds the counters and armed state cleared |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Address select for the service register |
| wrData | input | 8 | Write data byte |
| rateSel | input | RATE_W | Rate code selecting a post-divide of 4^code |
| resetReq | output | 1 | One-clock reset request on timeout |

## Verification
A service write takes effect at the clock edge that samples it. An expiry is detected at a base-tick edge and appears on resetReq one registered stage later, so the pulse can be seen on the clock after that edge. The bench drives on the falling edge, so its reference model and the RTL see the same inputs at each rising edge. It compares resetReq with the model every cycle. Timing checks measure the delay in cycles from the stimulus cycle to the pulse and compare it with the window that R3 gives. The bench shrinks the prescaler parameter so that even the longest rate finishes in about a thousand cycles.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [7:0] KEY_ARM   = 8'h55;
  localparam logic [7:0] KEY_CLEAR = 8'hAA;

  typedef struct packed {
    logic clearPost;
    logic advance;
  } wdgStrobe_t;
endpackage

// File: rtl/wdg_count.sv
module wdg_count
  import wdg_pkg::*;
#(
  parameter int PRE_BITS  = 15,
  parameter int RATE_W    = 2,
  parameter int RATE_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdgStrobe_t        strobe,
  input  logic [RATE_W-1:0] rateSel,
  output logic              baseTick,
  output logic              atLimit
);
  localparam int POST_W = RATE_STEP * ((1 << RATE_W) - 1) + 1;
  localparam logic [POST_W-1:0] MAX_LIMIT = POST_W'(1) << (POST_W - 1);

  logic [PRE_BITS-1:0] preCnt;
  logic [POST_W-1:0]   postCnt;
  logic [POST_W-1:0]   limitVal;

  // free-running prescaler: only the system reset clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + PRE_BITS'(1);
  end

  assign baseTick = &preCnt;
  assign limitVal = POST_W'(1) << (RATE_STEP * int'(rateSel));
  assign atLimit  = (postCnt == limitVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 postCnt <= '0;
    else if (strobe.clearPost) postCnt <= '0;
    else if (strobe.advance)   postCnt <= postCnt + POST_W'(1);
  end

  a_r2_prescale_wrap: assert property (@(posedge clk) disable iff (!rstN)
    baseTick |=> (preCnt == '0));
  a_r5_post_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearPost |=> (postCnt == '0));
  a_r3_post_bounded: assert property (@(posedge clk) disable iff (!rstN)
    postCnt <= MAX_LIMIT);
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrData,
  input  logic       baseTick,
  input  logic       atLimit,
  output wdgStrobe_t strobe,
  output logic       resetReq
);
  logic armed;
  logic tripped;
  logic live;
  logic svcWrite;
  logic svcClear;
  logic expire;

  assign live     = enable & ~tripped;
  assign svcWrite = wrEn & wrSel;
  assign svcClear = svcWrite & (wrData == KEY_CLEAR) & armed;
  assign expire   = live & baseTick & atLimit & ~svcClear;

  assign strobe.clearPost = ~live | svcClear | expire;
  assign strobe.advance   = baseTick & ~atLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      tripped  <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= expire;
      if (expire) tripped <= 1'b1;
      if (!live || expire)  armed <= 1'b0;
      else if (svcWrite)    armed <= (wrData == KEY_ARM);
    end
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
  a_r9_no_retrigger: assert property (@(posedge clk) disable iff (!rstN)
    tripped |=> !resetReq);
  a_r10_disable_disarms: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !armed);
  a_r4_arm_key: assert property (@(posedge clk) disable iff (!rstN)
    (live && !expire && svcWrite && wrData == KEY_ARM) |=> armed);
  a_r8_bad_key_disarms: assert property (@(posedge clk) disable iff (!rstN)
    (svcWrite && wrData != KEY_ARM && wrData != KEY_CLEAR) |=> !armed);
  a_r6_foreign_write_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (live && !expire && !svcWrite && armed) |=> armed);
endmodule

// File: rtl/wdg_keyed.sv
module wdg_keyed
  import wdg_pkg::*;
#(
  parameter int PRE_BITS  = 15,
  parameter int RATE_W    = 2,
  parameter int RATE_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [7:0]        wrData,
  input  logic [RATE_W-1:0] rateSel,
  output logic              resetReq
);
  wdgStrobe_t strobe;
  logic       baseTick;
  logic       atLimit;

  wdg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .baseTick (baseTick),
    .atLimit  (atLimit),
    .strobe   (strobe),
    .resetReq (resetReq)
  );

  wdg_count #(
    .PRE_BITS  (PRE_BITS),
    .RATE_W    (RATE_W),
    .RATE_STEP (RATE_STEP)
  ) u_count (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rateSel  (rateSel),
    .baseTick (baseTick),
    .atLimit  (atLimit)
  );
endmodule

// File: tb/sim_wdg_keyed.sv
module sim_wdg_keyed;
  localparam int CLK_PERIOD = 10;
  localparam int PRE_BITS   = 4;
  localparam int BASE       = 1 << PRE_BITS;
  localparam int MAX_CYC    = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [1:0] rateSel = 2'd0;
  logic       resetReq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int reqCount = 0;
  int reqAt = 0;

  // reference model state
  int  mPre, mPost;
  bit  mArmed, mTripped, expReq;

  wdg_keyed #(.PRE_BITS(PRE_BITS)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rateSel(rateSel), .resetReq(resetReq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPre = 0; mPost = 0; mArmed = 0; mTripped = 0; expReq = 0;
    end else begin
      bit tick, svc, wr;
      int lim;
      tick = (mPre == BASE - 1);
      mPre = (mPre + 1) % BASE;
      wr   = wrEn && wrSel;
      svc  = wr && wrData == 8'hAA && mArmed;
      lim  = 1 << (2 * int'(rateSel));
      expReq = 0;
      if (!enable || mTripped) begin
        mPost = 0; mArmed = 0;
      end else if (svc) begin
        mPost = 0; mArmed = 0;
      end else begin
        if (tick && mPost == lim) begin
          expReq = 1; mTripped = 1; mPost = 0; mArmed = 0;
        end else begin
          if (tick) mPost++;
          if (wr) begin
            if (wrData == 8'h55) mArmed = 1;
            else if (wrData != 8'hAA) mArmed = 0;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (resetReq === 1'b1) begin
      reqCount++;
      reqAt = cyc;
    end
    check(resetReq === expReq, "R9 resetReq vs model", int'(resetReq), int'(expReq));
    if (cyc > MAX_CYC) begin
      check(1'b0, "watchdog expired", cyc, MAX_CYC);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic busWr(input logic sel, input logic [7:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk); #1;
    wrEn = 1'b0; wrSel = 1'b0; wrData = 8'h00;
  endtask

  task automatic doReset();
    @(negedge clk); #1;
    rstN = 1'b0; enable = 1'b0;
    idle(3);
    rstN = 1'b1;
  endtask

  int c0, d, cnt0, dA, dB;

  initial begin
    doReset();
    // R1: reset state
    check(resetReq === 1'b0, "R1 resetReq after reset", int'(resetReq), 0);

    // R3 and R9 for every rate code
    for (int r = 0; r < 4; r++) begin
      int lim;
      lim = 1 << (2 * r);
      doReset();
      rateSel = 2'(r); enable = 1'b1;
      idle(5);
      busWr(1'b1, 8'h55);
      busWr(1'b0, 8'hAA);
      c0 = cyc;
      busWr(1'b1, 8'hAA);
      cnt0 = reqCount;
      idle(lim * BASE + BASE + 4);
      d = reqAt - c0 - 1;
      check(reqCount == cnt0 + 1, "R3 one timeout pulse", reqCount - cnt0, 1);
      check(d > lim * BASE && d <= (lim + 1) * BASE, "R3 timeout window", d, lim * BASE);
      busWr(1'b1, 8'h55);
      busWr(1'b1, 8'hAA);
      idle(3 * (lim + 1) * BASE);
      check(reqCount == cnt0 + 1, "R9 no pulse after trip", reqCount - cnt0, 1);
    end

    // R2: service phase changes the delay since prescaler is free running
    doReset();
    rateSel = 2'd0; enable = 1'b1;
    idle(2);
    busWr(1'b1, 8'h55); c0 = cyc; busWr(1'b1, 8'hAA);
    idle(3 * BASE); dA = reqAt - c0 - 1;
    doReset();
    enable = 1'b1;
    idle(7);
    busWr(1'b1, 8'h55); c0 = cyc; busWr(1'b1, 8'hAA);
    idle(3 * BASE); dB = reqAt - c0 - 1;
    check(dA != dB, "R2 phase-dependent delay", dA, dB + 1);
    check(dB > BASE && dB <= 2 * BASE, "R2 delay bound", dB, BASE);

    // R4 R5 R6: repeated service with foreign writes between keys
    doReset();
    rateSel = 2'd0; enable = 1'b1;
    cnt0 = reqCount;
    for (int i = 0; i < 12; i++) begin
      busWr(1'b1, 8'h55);
      busWr(1'b0, 8'h12);
      busWr(1'b0, 8'hAA);
      busWr(1'b0, 8'h00);
      busWr(1'b1, 8'hAA);
      idle(6);
    end
    check(reqCount == cnt0, "R6 kept alive across foreign writes", reqCount - cnt0, 0);
    check(reqCount == cnt0, "R4 R5 arm then clear services", reqCount - cnt0, 0);

    // R7: clear key without arming has no effect
    doReset();
    rateSel = 2'd1;
    c0 = cyc; enable = 1'b1;
    cnt0 = reqCount;
    for (int i = 0; i < 6; i++) begin
      busWr(1'b1, 8'hAA);
      idle(14);
    end
    d = reqAt - c0 - 1;
    check(reqCount == cnt0 + 1, "R7 unarmed clear ignored", reqCount - cnt0, 1);
    check(d >= 4 * BASE && d <= 5 * BASE, "R7 timeout from enable", d, 4 * BASE);

    // R8: other value between keys disarms
    doReset();
    rateSel = 2'd1;
    c0 = cyc; enable = 1'b1;
    cnt0 = reqCount;
    for (int i = 0; i < 5; i++) begin
      busWr(1'b1, 8'h55);
      busWr(1'b1, 8'h3C);
      busWr(1'b1, 8'hAA);
      idle(15);
    end
    d = reqAt - c0 - 1;
    check(reqCount == cnt0 + 1, "R8 bad key breaks sequence", reqCount - cnt0, 1);
    check(d >= 4 * BASE && d <= 5 * BASE, "R8 timeout from enable", d, 4 * BASE);

    // R10: disabled holds cleared and disarms
    doReset();
    rateSel = 2'd0;
    cnt0 = reqCount;
    idle(10 * BASE);
    check(reqCount == cnt0, "R10 no timeout while disabled", reqCount - cnt0, 0);
    busWr(1'b1, 8'h55);
    c0 = cyc; enable = 1'b1;
    busWr(1'b1, 8'hAA);
    idle(3 * BASE);
    d = reqAt - c0 - 1;
    check(reqCount == cnt0 + 1, "R10 arm while disabled discarded", reqCount - cnt0, 1);
    check(d >= BASE && d <= 2 * BASE, "R10 full timeout after enable", d, BASE);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule